// File: doc/BRIEF.md
# Timer Compare/Capture Status Unit

A 16-bit functional timer that keeps an 8-bit status word readable over a simple register bus. The timer holds an active period register and two active event registers (A and B), each with a buffer in front of it. Bus writes to the period and event addresses only change the buffers. A separate update-request strobe copies the buffers into the active registers. If the counter is running, the copy waits for the next period match. If it is stopped, the copy takes place on the next clock.

The counter runs in one of three compare modes or in capture mode. In the compare modes, the two event flags give the result of comparing the counter with each event register. In capture mode, each flag marks captured data that has not been read yet, and a read of that event address clears it. Software can start and stop the counter. A trigger pulse starts a single run, which ends at the period match and then locks out further trigger starts until the counter value is read.

Top module: `tmr_stat_unit`

## Requirements
- R1: After reset the status word (address 5) reads 0x30. Its bits are: bit 7 running, bit 6 start-lock, bit 5 event-B flag, bit 4 event-A flag, bit 0 update pending. Bits 3..1 always read 0.
- R2: In the compare modes (control mode field 0, 1 or 2), the event-A flag is 1 when counter >= active event A and 0 otherwise. The event-B flag follows the same rule against active event B.
- R3: In capture mode (mode field 3), a pulse on `cap_a_i` or `cap_b_i` stores the current counter value and sets that channel's flag. A bus read of address 2 (A) or 3 (B) returns the stored value and clears the flag. If a capture and a clearing read fall in the same cycle, the flag ends up 1.
- R4: Writing the control register (address 4) with bit 2 set starts the counter from 0. With bit 3 set, the write stops it and the counter value is held; stop wins if both bits are set. Bits 1..0 of the write set the mode. While running, the counter steps by 1 on each clock and returns to 0 on the clock after it equals the active period. The counter reads at address 0.
- R5: A `trig_i` pulse while the counter is stopped and start-lock is 0 starts a single run from 0. That run ends when the counter reaches the active period: the counter returns to 0, the running bit clears and start-lock becomes 1.
- R6: While start-lock is 1, `trig_i` does not start the counter. A bus read of address 0 clears start-lock on that clock.
- R7: An `upd_req_i` pulse sets update pending. The buffer-to-active copy, which also clears pending, happens at the next period match if the counter is running, or on the next clock if it is stopped.
- R8: Bus writes to the status address have no effect on the status word.
- R9: A capture that arrives while the channel flag is already 1 replaces the stored value, and the flag stays 1.
- R10: Bus writes to address 1 (period), 2 (event A) and 3 (event B) load only the buffers. Reads of these addresses in the compare modes return the active values, which do not change until the copy takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 3 | Register address |
| bus_rd_i | input | 1 | Read strobe; read side effects take place at the clock edge |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from the address |
| trig_i | input | 1 | Event trigger pulse for a single run |
| cap_a_i | input | 1 | Capture pulse, channel A |
| cap_b_i | input | 1 | Capture pulse, channel B |
| upd_req_i | input | 1 | Update-request strobe for the buffered registers |

## Verification
A corrupted counter or period register shows up on the next status read: both compare flags are derived from the counter, so they switch at the wrong count and the wrap lands on the wrong clock. A lost update-pending bit leaves the period or event readback stale after the expected copy point. A stuck pending bit shows as bit 0 staying set one clock after a stopped-counter request. A wrong start-lock or capture flag is visible at once: a trigger fails to start or starts when it should not, or a flag stays up after the clearing read. Each of these faults reaches the ports within one to two clocks of the event that exposes it.

// File: rtl/tmr_stat_pkg.sv
package tmr_stat_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER = 2'd0,
    MODE_PWM1  = 2'd1,
    MODE_PWM2  = 2'd2,
    MODE_CAPT  = 2'd3
  } tmr_mode_e;

  localparam int unsigned AW = 3;
  localparam logic [AW-1:0] ADR_CNT  = 3'd0;
  localparam logic [AW-1:0] ADR_PRD  = 3'd1;
  localparam logic [AW-1:0] ADR_EVA  = 3'd2;
  localparam logic [AW-1:0] ADR_EVB  = 3'd3;
  localparam logic [AW-1:0] ADR_CTRL = 3'd4;
  localparam logic [AW-1:0] ADR_STAT = 3'd5;

  localparam int unsigned CTRL_START_BIT = 2;
  localparam int unsigned CTRL_STOP_BIT  = 3;
  localparam int unsigned N_SLOT = 3;  // period, event A, event B
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sw_start_i,
  input  logic         sw_stop_i,
  input  logic         trig_i,
  input  logic         cnt_rd_i,
  input  logic [W-1:0] prd_i,
  output logic [W-1:0] cnt_o,
  output logic         run_o,
  output logic         lock_o,
  output logic         match_o
);
  logic [W-1:0] cnt_q;
  logic run_q, oneshot_q, lock_q;
  logic end_single;

  assign match_o    = run_q && (cnt_q == prd_i);
  assign end_single = match_o && oneshot_q && !sw_stop_i && !sw_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      run_q     <= 1'b0;
      oneshot_q <= 1'b0;
    end else if (sw_stop_i) begin
      run_q     <= 1'b0;
      oneshot_q <= 1'b0;
    end else if (sw_start_i) begin
      run_q     <= 1'b1;
      oneshot_q <= 1'b0;
      cnt_q     <= '0;
    end else if (!run_q && trig_i && !lock_q) begin
      run_q     <= 1'b1;
      oneshot_q <= 1'b1;
      cnt_q     <= '0;
    end else if (run_q) begin
      if (cnt_q == prd_i) begin
        cnt_q <= '0;
        if (oneshot_q) begin
          run_q     <= 1'b0;
          oneshot_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // set wins over read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         lock_q <= 1'b0;
    else if (end_single) lock_q <= 1'b1;
    else if (cnt_rd_i)   lock_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign run_o  = run_q;
  assign lock_o = lock_q;

  a_r6_lock_blocks_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q && !run_q && trig_i && !sw_start_i |=> !run_q);
  a_r4_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !match_o && !sw_stop_i && !sw_start_i |=> cnt_q == W'($past(cnt_q) + 1'b1));
  a_r4_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> cnt_q <= prd_i);
  a_r5_single_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_single |=> !run_q && lock_q && cnt_q == '0);
endmodule

// File: rtl/tmr_shadow.sv
module tmr_shadow
  import tmr_stat_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] PRD_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SLOT-1:0] wr_en_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              upd_req_i,
  input  logic              run_i,
  input  logic              match_i,
  output logic [W-1:0]      prd_o,
  output logic [W-1:0]      eva_o,
  output logic [W-1:0]      evb_o,
  output logic              pend_o
);
  logic [W-1:0] buf_q [N_SLOT];
  logic [W-1:0] act_q [N_SLOT];
  logic pend_q, xfer;

  assign xfer = pend_q && (!run_i || match_i);

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    localparam logic [W-1:0] RV = (g == 0) ? PRD_RST : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        buf_q[g] <= RV;
        act_q[g] <= RV;
      end else begin
        if (wr_en_i[g]) buf_q[g] <= wdata_i;
        if (xfer)       act_q[g] <= buf_q[g];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_q <= 1'b0;
    else if (upd_req_i) pend_q <= 1'b1;
    else if (xfer)      pend_q <= 1'b0;
  end

  assign prd_o  = act_q[0];
  assign eva_o  = act_q[1];
  assign evb_o  = act_q[2];
  assign pend_o = pend_q;

  a_r7_req_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_req_i |=> pend_q);
  a_r7_stopped_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !run_i && !upd_req_i |=> !pend_q);
  a_r10_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q |=> $stable(prd_o) && $stable(eva_o) && $stable(evb_o));
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         cap_i,
  input  logic         clr_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] data_o,
  output logic         flag_o
);
  logic [W-1:0] data_q;
  logic flag_q, hit;

  assign hit = en_i && cap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      flag_q <= 1'b0;
    end else if (hit) begin
      data_q <= cnt_i;
      flag_q <= 1'b1;
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign flag_o = flag_q;

  a_r3_capture_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> flag_q && data_q == $past(cnt_i));
  a_r3_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !hit |=> !flag_q);
endmodule

// File: rtl/tmr_stat_unit.sv
module tmr_stat_unit
  import tmr_stat_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_rd_i,
  input  logic          bus_wr_i,
  input  logic [W-1:0]  bus_wdata_i,
  output logic [W-1:0]  bus_rdata_o,
  input  logic          trig_i,
  input  logic          cap_a_i,
  input  logic          cap_b_i,
  input  logic          upd_req_i
);
  localparam int unsigned SW = 8;

  tmr_mode_e mode_q;
  logic [W-1:0] cnt, prd, eva, evb, cap_a_d, cap_b_d;
  logic run, lock, match, pend, cap_a_f, cap_b_f;
  logic capt, flag_a, flag_b, sw_start, sw_stop, ctrl_wr;
  logic [N_SLOT-1:0] buf_wr;
  logic [SW-1:0] stat;

  assign capt     = (mode_q == MODE_CAPT);
  assign ctrl_wr  = bus_wr_i && (bus_addr_i == ADR_CTRL);
  assign sw_start = ctrl_wr && bus_wdata_i[CTRL_START_BIT];
  assign sw_stop  = ctrl_wr && bus_wdata_i[CTRL_STOP_BIT];
  assign buf_wr   = {bus_wr_i && (bus_addr_i == ADR_EVB),
                     bus_wr_i && (bus_addr_i == ADR_EVA),
                     bus_wr_i && (bus_addr_i == ADR_PRD)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= MODE_TIMER;
    else if (ctrl_wr) mode_q <= tmr_mode_e'(bus_wdata_i[1:0]);
  end

  tmr_counter #(.W(W)) u_cnt (
    .clk_i, .rst_ni,
    .sw_start_i(sw_start), .sw_stop_i(sw_stop), .trig_i,
    .cnt_rd_i(bus_rd_i && (bus_addr_i == ADR_CNT)),
    .prd_i(prd), .cnt_o(cnt), .run_o(run), .lock_o(lock), .match_o(match)
  );

  tmr_shadow #(.W(W)) u_shd (
    .clk_i, .rst_ni, .wr_en_i(buf_wr), .wdata_i(bus_wdata_i), .upd_req_i,
    .run_i(run), .match_i(match),
    .prd_o(prd), .eva_o(eva), .evb_o(evb), .pend_o(pend)
  );

  tmr_capture #(.W(W)) u_cap_a (
    .clk_i, .rst_ni, .en_i(capt), .cap_i(cap_a_i),
    .clr_i(bus_rd_i && (bus_addr_i == ADR_EVA)),
    .cnt_i(cnt), .data_o(cap_a_d), .flag_o(cap_a_f)
  );

  tmr_capture #(.W(W)) u_cap_b (
    .clk_i, .rst_ni, .en_i(capt), .cap_i(cap_b_i),
    .clr_i(bus_rd_i && (bus_addr_i == ADR_EVB)),
    .cnt_i(cnt), .data_o(cap_b_d), .flag_o(cap_b_f)
  );

  assign flag_a = capt ? cap_a_f : (cnt >= eva);
  assign flag_b = capt ? cap_b_f : (cnt >= evb);
  assign stat   = {run, lock, flag_b, flag_a, 3'b000, pend};

  always_comb begin
    case (bus_addr_i)
      ADR_CNT:  bus_rdata_o = cnt;
      ADR_PRD:  bus_rdata_o = prd;
      ADR_EVA:  bus_rdata_o = capt ? cap_a_d : eva;
      ADR_EVB:  bus_rdata_o = capt ? cap_b_d : evb;
      ADR_CTRL: bus_rdata_o = {{(W-2){1'b0}}, mode_q};
      ADR_STAT: bus_rdata_o = {{(W-SW){1'b0}}, stat};
      default:  bus_rdata_o = '0;
    endcase
  end

  a_r8_stat_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_i && bus_addr_i == ADR_STAT && !upd_req_i && !pend |=> !pend);
endmodule

// File: tb/sim_tmr_stat_unit.sv
module sim_tmr_stat_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic rd = 1'b0, wr = 1'b0, trig = 1'b0, cap_a = 1'b0, cap_b = 1'b0, upd = 1'b0;
  logic [15:0] wdata = '0, rdata;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_stat_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_rd_i(rd), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .trig_i(trig), .cap_a_i(cap_a),
    .cap_b_i(cap_b), .upd_req_i(upd)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=0x%04h exp=0x%04h", req, got, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1; tick(); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
    addr = a; rd = 1'b1; #1 d = rdata; tick(); rd = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string req);
    logic [15:0] d;
    bus_rd(a, d); chk(req, d, exp);
  endtask

  task automatic pulse(ref logic s); s = 1'b1; tick(); s = 1'b0; endtask

  task automatic t_reset();
    rd_chk(3'd5, 16'h0030, "R1 reset status");
    rd_chk(3'd0, 16'h0000, "R1 reset counter");
  endtask

  task automatic t_compare();
    bus_wr(3'd1, 16'd20); bus_wr(3'd2, 16'd5); bus_wr(3'd3, 16'd8);
    rd_chk(3'd2, 16'd0, "R10 event A unchanged before copy");
    pulse(upd);
    rd_chk(3'd5, 16'h0031, "R7 pending set");
    rd_chk(3'd5, 16'h0000, "R7 stopped copy clears pending");
    rd_chk(3'd2, 16'd5, "R10 event A copied");
    rd_chk(3'd1, 16'd20, "R10 period copied");
    bus_wr(3'd4, 16'h0004);
    repeat (4) tick();
    rd_chk(3'd5, 16'h0080, "R2 cnt4 below A");
    rd_chk(3'd5, 16'h0090, "R2 cnt5 reaches A");
    rd_chk(3'd0, 16'd6, "R4 counting");
    rd_chk(3'd5, 16'h0090, "R2 cnt7");
    rd_chk(3'd5, 16'h00B0, "R2 cnt8 reaches B");
    repeat (11) tick();
    rd_chk(3'd0, 16'd20, "R4 at period");
    rd_chk(3'd0, 16'd0, "R4 wrap");
    bus_wr(3'd4, 16'h0008);
    rd_chk(3'd5, 16'h0000, "R4 stopped");
    rd_chk(3'd0, 16'd1, "R4 counter held");
  endtask

  task automatic t_update_running();
    bus_wr(3'd4, 16'h0004);
    bus_wr(3'd1, 16'd6);
    pulse(upd);
    rd_chk(3'd5, 16'h0081, "R7 pending while running");
    rd_chk(3'd1, 16'd20, "R10 period held until match");
    repeat (16) tick();
    rd_chk(3'd5, 16'h00B1, "R7 pending at match cycle");
    rd_chk(3'd1, 16'd6, "R7 period copied at match");
    rd_chk(3'd5, 16'h0080, "R7 pending cleared");
    repeat (4) tick();
    rd_chk(3'd0, 16'd6, "R4 new period reached");
    rd_chk(3'd0, 16'd0, "R4 wrap at new period");
    bus_wr(3'd4, 16'h0008);
  endtask

  task automatic t_single_lock();
    pulse(trig);
    rd_chk(3'd5, 16'h0080, "R5 trigger starts");
    repeat (4) tick();
    rd_chk(3'd5, 16'h0090, "R5 cnt5");
    rd_chk(3'd5, 16'h0090, "R5 cnt at period");
    rd_chk(3'd5, 16'h0040, "R5 single run ends with lock");
    pulse(trig);
    rd_chk(3'd5, 16'h0040, "R6 trigger blocked by lock");
    rd_chk(3'd0, 16'd0, "R6 counter read");
    rd_chk(3'd5, 16'h0000, "R6 lock cleared by counter read");
    pulse(trig);
    rd_chk(3'd5, 16'h0080, "R6 trigger after unlock");
    bus_wr(3'd4, 16'h0008);
    rd_chk(3'd5, 16'h0000, "R4 software stop no lock");
  endtask

  task automatic t_capture();
    logic [15:0] d;
    bus_wr(3'd4, 16'h0003);
    rd_chk(3'd5, 16'h0000, "R3 capture mode no data");
    bus_wr(3'd4, 16'h0007);
    tick(); tick();
    pulse(cap_a);
    rd_chk(3'd5, 16'h0090, "R3 flag A set");
    rd_chk(3'd2, 16'd2, "R3 captured A value");
    rd_chk(3'd5, 16'h0080, "R3 flag A cleared by read");
    pulse(cap_b);
    pulse(cap_b);
    rd_chk(3'd5, 16'h00A0, "R9 flag B kept");
    rd_chk(3'd3, 16'd0, "R9 value overwritten");
    cap_b = 1'b1; bus_rd(3'd3, d); cap_b = 1'b0;
    chk("R3 read data before capture", d, 16'd0);
    rd_chk(3'd5, 16'h00A0, "R3 set wins over read clear");
    rd_chk(3'd3, 16'd3, "R3 captured B value");
    bus_wr(3'd4, 16'h0008);
  endtask

  task automatic t_stat_write();
    rd_chk(3'd5, 16'h0010, "R8 status before write");
    bus_wr(3'd5, 16'h00FF);
    rd_chk(3'd5, 16'h0010, "R8 status write ignored");
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_compare();
    t_update_running();
    t_single_lock();
    t_capture();
    t_stat_write();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule